// File: doc/BRIEF.md
# Hall-Commutated Unipolar PWM Gate Mapper for a Three-Phase Bridge

This block turns a duty-cycle value and the three Hall sensor lines of a brushless DC motor into six gate-drive enables for a three-phase bridge. A free-running counter with a compare stage makes one PWM waveform. The Hall code selects one of six commutation vectors. Each vector sends that single PWM to one high-side switch and one low-side switch, and the two switches belong to different phases. The other four switches stay off.

A direction input reverses the rotation sequence. Hall codes with all lines equal do not occur on a healthy sensor. On such a code the block switches every gate off and raises a fault output. The duty value is sampled only at a period boundary, so a change in the middle of a period cannot cut a pulse short. An enable input removes drive from all gates on the next clock.

Dead time, the analog gate drivers and speed regulation are handled elsewhere. The block is a pure mapping stage with registered outputs.

Top module: `bldc_gate_mapper`

## Requirements
- R1: A counter of CNT_W bits (period 2^CNT_W clocks, 256 by default) starts at 0 after reset and wraps from its all-ones value to 0. For a latched duty D with 0 < D < all-ones, the PWM is high during the first D counts of each period (count < D).
- R2: A latched duty of 0 keeps the PWM low for the whole period. An all-ones duty (255 by default) keeps it high for the whole period.
- R3: The duty input is latched only on the clock edge where the counter wraps from all-ones to 0. At any other time a change of the duty input has no effect on the current period.
- R4: With dir = 0 the Hall code (bit2..bit0) selects the driven phases, where phase A = bit 0, B = bit 1 and C = bit 2 of each gate bus: 001 → high A / low B, 011 → high A / low C, 010 → high B / low C, 110 → high B / low A, 100 → high C / low A, 101 → high C / low B.
- R5: With dir = 1 the high-side and low-side phases of each entry in R4 are exchanged.
- R6: At most one high-side gate and at most one low-side gate are on at any time, never in the same phase. The two selected gates both carry the same PWM, and all other gates are off.
- R7: A Hall code of 000 or 111 turns all six gates off and sets fault. fault is 0 for every valid code and does not depend on the enable.
- R8: While en = 0 all six gates are off from the next clock on.
- R9: A synchronous active-high reset clears the gates, fault, the counter and the latched duty (to 0).
- R10: The gates and fault are registered. They reflect the counter, latched duty, Hall code, dir and en of the previous clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Drive enable; 0 turns off all gates |
| dir | input | 1 | Rotation direction; 1 reverses the sequence |
| hall | input | 3 | Hall sensor code, bit 0 = sensor of phase A |
| duty | input | CNT_W | Requested duty, latched at period start |
| gate_hi | output | 3 | High-side gate enables, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate enables, bit 0 = phase A |
| fault | output | 1 | Invalid Hall code seen |

## Verification
The bench builds the block with the default CNT_W of 8. A full period then lasts 256 clocks, so every Hall code in both directions is held across several whole periods within a short run. The small width also lets the bench reach both duty limits and a duty change in the middle of a period many times. At this width the bench can compare the exact gate pattern against its own model on every clock, including the clocks right after a wrap, an enable change and a reset.

// File: rtl/bgm_pkg.sv
package bgm_pkg;

    localparam int PHASES = 3;

    typedef logic [PHASES-1:0] phase_mask_t;

    // One commutation choice: which phase is switched high, which low.
    typedef struct packed {
        logic        valid;
        phase_mask_t hi;
        phase_mask_t lo;
    } comm_vec_t;

    // Sector table for the forward direction; reverse swaps the sides.
    function automatic comm_vec_t hall_to_vec(input logic [2:0] code, input logic rev);
        comm_vec_t v;
        v.valid = 1'b1;
        unique case (code)
            3'b001:  begin v.hi = 3'b001; v.lo = 3'b010; end
            3'b011:  begin v.hi = 3'b001; v.lo = 3'b100; end
            3'b010:  begin v.hi = 3'b010; v.lo = 3'b100; end
            3'b110:  begin v.hi = 3'b010; v.lo = 3'b001; end
            3'b100:  begin v.hi = 3'b100; v.lo = 3'b001; end
            3'b101:  begin v.hi = 3'b100; v.lo = 3'b010; end
            default: begin v.hi = '0; v.lo = '0; v.valid = 1'b0; end
        endcase
        if (rev) begin
            phase_mask_t t;
            t    = v.hi;
            v.hi = v.lo;
            v.lo = t;
        end
        return v;
    endfunction

endpackage

// File: rtl/bgm_pwm_gen.sv
module bgm_pwm_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] duty_sh;
    logic             wrap;

    assign wrap = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            duty_sh <= '0;
        end else begin
            cnt <= cnt + 1'b1;
            if (wrap) duty_sh <= duty_in;
        end
    end

    // Full-scale duty pins the output high; otherwise compare.
    assign pwm = (duty_sh == CNT_MAX) || (cnt < duty_sh);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    // R3
    duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(duty_sh));

    // R2
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (duty_sh == '0) |-> !pwm);

endmodule

// File: rtl/bgm_commutator.sv
module bgm_commutator
    import bgm_pkg::*;
(
    input  logic [2:0] hall,
    input  logic       dir,
    output comm_vec_t  vec
);
    always_comb vec = hall_to_vec(hall, dir);
endmodule

// File: rtl/bgm_gate_stage.sv
module bgm_gate_stage
    import bgm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        pwm,
    input  comm_vec_t   vec,
    output phase_mask_t gate_hi,
    output phase_mask_t gate_lo,
    output logic        fault
);
    logic drive;

    assign drive = en && vec.valid && pwm;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_hi <= '0;
            gate_lo <= '0;
            fault   <= 1'b0;
        end else begin
            gate_hi <= drive ? vec.hi : '0;
            gate_lo <= drive ? vec.lo : '0;
            fault   <= !vec.valid;
        end
    end

    // R6
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_hi) && $onehot0(gate_lo) && ((gate_hi & gate_lo) == '0)
        && ((gate_hi == '0) == (gate_lo == '0)));

    // R8
    enable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_hi == '0) && (gate_lo == '0));

    // R7
    bad_hall_chk: assert property (@(posedge clk) disable iff (rst)
        !vec.valid |=> fault && (gate_hi == '0) && (gate_lo == '0));

endmodule

// File: rtl/bldc_gate_mapper.sv
module bldc_gate_mapper
    import bgm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir,
    input  logic [2:0]       hall,
    input  logic [CNT_W-1:0] duty,
    output logic [2:0]       gate_hi,
    output logic [2:0]       gate_lo,
    output logic             fault
);
    logic      pwm;
    comm_vec_t vec;

    bgm_pwm_gen #(.CNT_W(CNT_W)) u_pwm (
        .clk     (clk),
        .rst     (rst),
        .duty_in (duty),
        .pwm     (pwm)
    );

    bgm_commutator u_comm (
        .hall (hall),
        .dir  (dir),
        .vec  (vec)
    );

    bgm_gate_stage u_gate (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .pwm     (pwm),
        .vec     (vec),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo),
        .fault   (fault)
    );

endmodule

// File: tb/sim_bldc_gate_mapper.sv
`timescale 1ns/1ps
module sim_bldc_gate_mapper;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       dir = 1'b0;
    logic [2:0] hall = 3'b001;
    logic [7:0] duty = 8'd0;
    logic [2:0] gate_hi, gate_lo;
    logic       fault;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bldc_gate_mapper #(.CNT_W(8)) u0 (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .hall(hall),
        .duty(duty), .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
    );

    // Behavioural reference: sector index and phase choices per sector.
    int sector_of [8] = '{-1, 0, 2, 1, 4, 5, 3, -1};
    int hi_ph     [6] = '{0, 0, 1, 1, 2, 2};
    int lo_ph     [6] = '{1, 2, 2, 0, 0, 1};

    int         m_cnt = 0;
    int         m_sh  = 0;
    logic [2:0] e_hi  = '0;
    logic [2:0] e_lo  = '0;
    logic       e_f   = 1'b0;
    logic       e_pwm_on = 1'b0;
    string      e_tag = "R9";
    string      phase_tag = "R4";

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sh = 0;
            e_hi = '0; e_lo = '0; e_f = 1'b0; e_pwm_on = 1'b0;
            e_tag = "R9";
        end else begin
            int  s;
            bit  p;
            int  h, l;
            s = sector_of[hall];
            p = (m_sh >= 255) ? 1'b1 : (m_cnt < m_sh);
            e_f = (s < 0);
            e_hi = '0; e_lo = '0;
            e_pwm_on = en && (s >= 0) && p;
            if (e_pwm_on) begin
                h = dir ? lo_ph[s] : hi_ph[s];
                l = dir ? hi_ph[s] : lo_ph[s];
                e_hi[h] = 1'b1;
                e_lo[l] = 1'b1;
            end
            if (!en)                      e_tag = "R8";
            else if (s < 0)               e_tag = "R7";
            else if (m_sh == 0 || m_sh == 255) e_tag = "R2";
            else                          e_tag = phase_tag;
            if (m_cnt == 255) m_sh = int'(duty);
            m_cnt = (m_cnt + 1) % 256;
        end
    end

    always @(negedge clk) begin
        checks++;
        if (gate_hi !== e_hi || gate_lo !== e_lo || fault !== e_f) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b fault=%b expected hi=%b lo=%b fault=%b",
                     e_tag, gate_hi, gate_lo, fault, e_hi, e_lo, e_f);
        end
        checks++;
        if (((gate_hi != 0) !== e_pwm_on) || ((gate_lo != 0) !== e_pwm_on)) begin
            errors++;
            $display("FAIL R1/R10 pwm level: hi=%b lo=%b expected on=%b",
                     gate_hi, gate_lo, e_pwm_on);
        end
        checks++;
        if ($countones(gate_hi) > 1 || $countones(gate_lo) > 1 || (gate_hi & gate_lo) != 0) begin
            errors++;
            $display("FAIL R6: hi=%b lo=%b expected one leg per side in different phases",
                     gate_hi, gate_lo);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sweep_halls(input int hold);
        logic [2:0] codes [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        foreach (codes[i]) begin
            hall = codes[i];
            run(hold);
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        run(4);
        rst = 1'b0;
        en  = 1'b1;
        // R1, R4: mid-range duties, forward sequence
        phase_tag = "R4";
        duty = 8'd64;
        sweep_halls(600);
        duty = 8'd200;
        sweep_halls(520);
        // R5: reversed sequence
        phase_tag = "R5";
        dir = 1'b1;
        sweep_halls(520);
        dir = 1'b0;
        // R2: duty limits
        duty = 8'd0;
        sweep_halls(300);
        duty = 8'd255;
        sweep_halls(300);
        duty = 8'd1;
        run(600);
        duty = 8'd254;
        run(600);
        // R3: duty changes inside a period
        phase_tag = "R3";
        hall = 3'b011;
        for (int k = 0; k < 60; k++) begin
            duty = 8'(10 + (k * 37) % 230);
            run(29 + (k % 7) * 11);
        end
        // R7: invalid Hall codes, enabled and disabled
        phase_tag = "R4";
        duty = 8'd128;
        hall = 3'b000; run(300);
        hall = 3'b101; run(300);
        hall = 3'b111; run(300);
        en = 1'b0; run(50);
        en = 1'b1;
        hall = 3'b110; run(300);
        // R8: enable toggling inside pulses
        for (int k = 0; k < 20; k++) begin
            en = 1'b0; run(3 + k);
            en = 1'b1; run(17 + 5 * k);
        end
        // R9: reset in the middle of a period
        run(77);
        rst = 1'b1; run(3);
        rst = 1'b0;
        duty = 8'd90; dir = 1'b1;
        sweep_halls(300);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule